// File: doc/BRIEF.md
# CD Decoder Host Register Window

This block is the byte-wide register window that a sub-processor uses to program and monitor a CD data decoder. The processor points a 4-bit index at one of sixteen byte registers and then issues read or write strobes. Reads and writes see two different maps at the same index. After most accesses the index steps forward by itself, so the processor can sweep a group of related registers with strobes alone. The index can also be loaded directly.

Internally the window holds the interface control and status bytes, a 16-bit transfer byte count, a 16-bit data address, a pointer, a write address, three control bytes and the last status byte. The header bytes are produced from the current BCD minute, second and frame inputs. The block records which header and status registers have been read. When the final status byte is read and the decoder has been fully polled, that record is used to re-arm the decode status flag.

A separate transfer engine receives one-cycle start, stop and acknowledge pulses together with the byte count and data address. It reports completion through a pulse input, and the decoder reports a finished sector the same way.

Top module: `cdc_regwin`

## Requirements
- R1: After reset the index is 0 and the read registers are: command-in 0x00, interface status 0xFF, byte count 0, header {BCD min, sec, frame, 0x01}, pointer 0, write address 4704 (0x1260), status bytes 0x80, 0x00, 0x00, 0x00. The data address, control bytes, interface control and sub-header-out registers are 0, and no pulse is active.
- R2: A read or write strobe at index n leaves the index at n+1 (mod 16) on the next edge. The exceptions are a read at index 15 and writes at indices 6, 7, 14 and 15, which leave the index unchanged.
- R3: When `idx_set` is high at an edge, the index takes `idx_val`. This overrides the step of R2. Any access in the same cycle still uses the old index for its data and side effects.
- R4: The read map is: 0 command-in, 1 interface status, 2/3 byte count low/high, 4-7 header, 8/9 pointer low/high, 10/11 write address low/high, 12-15 status 0-3. The write map is: 0 sub-header out, 1 interface control, 2/3 byte count, 4/5 data address, 8/9 write address, 10/11 control 0/1, 12/13 pointer, 14 control 2. Read data follows the current index combinationally. A read and a write strobe in the same cycle are illegal.
- R5: When control-1 bit 0 is set, header bytes 4-7 read as 0x00. Otherwise they read as minute, second, frame and 0x01.
- R6: Writing interface control (index 1) with bit 1 clear zeroes the byte count, sets interface status bit 3, and raises `xfer_stop` for the following cycle.
- R7: Writing index 6 while interface-control bit 1 is set clears interface status bit 3 and raises `xfer_start` for the following cycle. With bit 1 clear the write has no effect.
- R8: Writing index 7 sets interface status bit 6 and raises `xfer_ack` for the following cycle.
- R9: An `xfer_end` pulse sets interface status bit 3. If interface-control bit 6 is set, the pulse also clears interface status bit 6, which is the active-low end-of-transfer flag.
- R10: Reading index 15 sets interface status bit 5. A `dec_done` pulse clears that bit.
- R11: A read at indices 1, 4-9 or 12-14 sets that index's bit in a 16-bit read record. A read at index 15 sets status byte 3 to 0x80, effective for later reads, only when control-0 bit 7 and interface-control bit 5 are both set and the record covers every bit of 0x73F2. The read itself returns the old value.
- R12: Writing index 15 restores every register and the read record to the R1 values, while the index stays at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one access per cycle high |
| wr_stb | input | 1 | Write strobe, one access per cycle high |
| idx_set | input | 1 | Load the index from idx_val |
| idx_val | input | 4 | Index value to load |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register at the current index (read map) |
| cur_idx | output | 4 | Current register index |
| bcd_min | input | 8 | BCD minute for the header |
| bcd_sec | input | 8 | BCD second for the header |
| bcd_frm | input | 8 | BCD frame for the header |
| xfer_end | input | 1 | Transfer engine finished |
| dec_done | input | 1 | Decoder finished a sector |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_stop | output | 1 | Stop pulse to the transfer engine |
| xfer_ack | output | 1 | Acknowledge pulse to the transfer engine |
| byte_cnt | output | 16 | Transfer byte count |
| data_addr | output | 16 | Transfer data address |
| ctrl_word | output | 24 | Control bytes {2, 1, 0} |
| subhdr_out | output | 8 | Sub-header output byte |

## Verification
A wrong index step shows up on the very next access: the data returned, or the register a write lands in, belongs to the wrong index. A later read-back then exposes it within a few strobes. Faults in the interface status bits are visible as soon as index 1 is read after the event that should have changed them. A wrong read record is hidden until a read at index 15 under the enable conditions, and the following read of that index then returns 0x80 when it should not, or fails to. The bench therefore runs that test both with a partial record and with a full one.

// File: rtl/cdc_regwin_pkg.sv
package cdc_regwin_pkg;

    localparam int DW   = 8;
    localparam int IW   = 4;
    localparam int NREG = 1 << IW;
    localparam int CW   = 2 * DW;

    localparam logic [CW-1:0]   WA_RST     = 16'd4704;
    localparam logic [DW-1:0]   IFS_RST    = 8'hFF;
    localparam logic [DW-1:0]   ST0_RST    = 8'h80;
    localparam logic [DW-1:0]   ST3_ARMED  = 8'h80;
    localparam logic [DW-1:0]   HDR_MODE   = 8'h01;
    localparam logic [NREG-1:0] TRACK_SET  = 16'h73F2;
    localparam logic [NREG-1:0] RD_HOLD    = 16'h8000;
    localparam logic [NREG-1:0] WR_HOLD    = 16'hC0C0;

    // interface control bits
    localparam int IFC_XFER_EN = 1;
    localparam int IFC_DEC_IE  = 5;
    localparam int IFC_END_IE  = 6;
    // interface status bits (active low flags)
    localparam int IFS_IDLE    = 3;
    localparam int IFS_DEC_N   = 5;
    localparam int IFS_END_N   = 6;
    // control bits
    localparam int C0_DEC_EN   = 7;
    localparam int C1_SUBHDR   = 0;

    typedef enum logic [IW-1:0] {
        WI_SUBHDR, WI_IFCTRL, WI_CNT_LO, WI_CNT_HI,
        WI_ADR_LO, WI_ADR_HI, WI_TRIG,   WI_ACK,
        WI_WA_LO,  WI_WA_HI,  WI_CTL0,   WI_CTL1,
        WI_PTR_LO, WI_PTR_HI, WI_CTL2,   WI_SRST
    } wr_idx_e;

    typedef enum logic [IW-1:0] {
        RI_CMDIN,  RI_IFSTAT, RI_CNT_LO, RI_CNT_HI,
        RI_HDR0,   RI_HDR1,   RI_HDR2,   RI_HDR3,
        RI_PTR_LO, RI_PTR_HI, RI_WA_LO,  RI_WA_HI,
        RI_ST0,    RI_ST1,    RI_ST2,    RI_ST3
    } rd_idx_e;

    typedef struct packed {
        logic [IW-1:0]   idx;
        logic [DW-1:0]   ifstat;
        logic [DW-1:0]   ifctrl;
        logic [DW-1:0]   sbout;
        logic [DW-1:0]   stat3;
        logic [CW-1:0]   dbc;
        logic [CW-1:0]   dac;
        logic [CW-1:0]   pt;
        logic [CW-1:0]   wa;
        logic [DW-1:0]   ctrl0;
        logic [DW-1:0]   ctrl1;
        logic [DW-1:0]   ctrl2;
        logic [NREG-1:0] rmask;
        logic            start;
        logic            stop;
        logic            ack;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s        = '0;
        s.ifstat = IFS_RST;
        s.wa     = WA_RST;
        return s;
    endfunction

endpackage

// File: rtl/cdc_index_seq.sv
module cdc_index_seq
    import cdc_regwin_pkg::*;
#(
    parameter logic [NREG-1:0] RD_STAY = RD_HOLD,
    parameter logic [NREG-1:0] WR_STAY = WR_HOLD
) (
    input  logic [IW-1:0] idx_q,
    input  logic          rd,
    input  logic          wr,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    output logic [IW-1:0] idx_d
);
    logic step;

    always_comb begin
        step = (rd && !RD_STAY[idx_q]) || (wr && !WR_STAY[idx_q]);
        if (load) begin
            idx_d = load_val;
        end else if (step) begin
            idx_d = idx_q + IW'(1);
        end else begin
            idx_d = idx_q;
        end
    end
endmodule

// File: rtl/cdc_header_gen.sv
module cdc_header_gen
    import cdc_regwin_pkg::*;
(
    input  logic                 sub_hdr,
    input  logic [DW-1:0]        bcd_min,
    input  logic [DW-1:0]        bcd_sec,
    input  logic [DW-1:0]        bcd_frm,
    output logic [3:0][DW-1:0]   hdr
);
    always_comb begin
        if (sub_hdr) begin
            hdr = '0;
        end else begin
            hdr[0] = bcd_min;
            hdr[1] = bcd_sec;
            hdr[2] = bcd_frm;
            hdr[3] = HDR_MODE;
        end
    end
endmodule

// File: rtl/cdc_read_mux.sv
module cdc_read_mux
    import cdc_regwin_pkg::*;
(
    input  logic [IW-1:0]      idx,
    input  logic [DW-1:0]      ifstat,
    input  logic [CW-1:0]      dbc,
    input  logic [3:0][DW-1:0] hdr,
    input  logic [CW-1:0]      pt,
    input  logic [CW-1:0]      wa,
    input  logic [DW-1:0]      stat3,
    output logic [DW-1:0]      rdata,
    output logic [NREG-1:0]    trk
);
    logic [NREG-1:0] sel;

    always_comb begin
        sel = NREG'(1) << idx;
        trk = sel & TRACK_SET;
        unique case (rd_idx_e'(idx))
            RI_CMDIN:  rdata = '0;
            RI_IFSTAT: rdata = ifstat;
            RI_CNT_LO: rdata = dbc[DW-1:0];
            RI_CNT_HI: rdata = dbc[CW-1:DW];
            RI_HDR0:   rdata = hdr[0];
            RI_HDR1:   rdata = hdr[1];
            RI_HDR2:   rdata = hdr[2];
            RI_HDR3:   rdata = hdr[3];
            RI_PTR_LO: rdata = pt[DW-1:0];
            RI_PTR_HI: rdata = pt[CW-1:DW];
            RI_WA_LO:  rdata = wa[DW-1:0];
            RI_WA_HI:  rdata = wa[CW-1:DW];
            RI_ST0:    rdata = ST0_RST;
            RI_ST1:    rdata = '0;
            RI_ST2:    rdata = '0;
            RI_ST3:    rdata = stat3;
        endcase
    end
endmodule

// File: rtl/cdc_regwin.sv
module cdc_regwin
    import cdc_regwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic            wr_stb,
    input  logic            idx_set,
    input  logic [3:0]      idx_val,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    output logic [3:0]      cur_idx,
    input  logic [7:0]      bcd_min,
    input  logic [7:0]      bcd_sec,
    input  logic [7:0]      bcd_frm,
    input  logic            xfer_end,
    input  logic            dec_done,
    output logic            xfer_start,
    output logic            xfer_stop,
    output logic            xfer_ack,
    output logic [15:0]     byte_cnt,
    output logic [15:0]     data_addr,
    output logic [23:0]     ctrl_word,
    output logic [7:0]      subhdr_out
);
    state_t              st_q, st_d;
    logic [IW-1:0]       idx_d;
    logic [3:0][DW-1:0]  hdr;
    logic [NREG-1:0]     trk;
    logic                rearm;

    cdc_index_seq u_idx (
        .idx_q    (st_q.idx),
        .rd       (rd_stb),
        .wr       (wr_stb),
        .load     (idx_set),
        .load_val (idx_val),
        .idx_d    (idx_d)
    );

    cdc_header_gen u_hdr (
        .sub_hdr (st_q.ctrl1[C1_SUBHDR]),
        .bcd_min (bcd_min),
        .bcd_sec (bcd_sec),
        .bcd_frm (bcd_frm),
        .hdr     (hdr)
    );

    cdc_read_mux u_rmux (
        .idx    (st_q.idx),
        .ifstat (st_q.ifstat),
        .dbc    (st_q.dbc),
        .hdr    (hdr),
        .pt     (st_q.pt),
        .wa     (st_q.wa),
        .stat3  (st_q.stat3),
        .rdata  (rd_data),
        .trk    (trk)
    );

    always_comb begin
        rearm = st_q.ctrl0[C0_DEC_EN] && st_q.ifctrl[IFC_DEC_IE]
             && ((st_q.rmask & TRACK_SET) == TRACK_SET);

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.stop  = 1'b0;
        st_d.ack   = 1'b0;

        // events from the transfer engine and decoder
        if (xfer_end) begin
            st_d.ifstat[IFS_IDLE] = 1'b1;
            if (st_q.ifctrl[IFC_END_IE]) begin
                st_d.ifstat[IFS_END_N] = 1'b0;
            end
        end
        if (dec_done) begin
            st_d.ifstat[IFS_DEC_N] = 1'b0;
        end

        // host read side effects
        if (rd_stb) begin
            st_d.rmask = st_q.rmask | trk;
            if (rd_idx_e'(st_q.idx) == RI_ST3) begin
                st_d.ifstat[IFS_DEC_N] = 1'b1;
                if (rearm) begin
                    st_d.stat3 = ST3_ARMED;
                end
            end
        end

        // host writes
        if (wr_stb) begin
            unique case (wr_idx_e'(st_q.idx))
                WI_SUBHDR: st_d.sbout = wr_data;
                WI_IFCTRL: begin
                    st_d.ifctrl = wr_data;
                    if (!wr_data[IFC_XFER_EN]) begin
                        st_d.dbc              = '0;
                        st_d.ifstat[IFS_IDLE] = 1'b1;
                        st_d.stop             = 1'b1;
                    end
                end
                WI_CNT_LO: st_d.dbc[DW-1:0]  = wr_data;
                WI_CNT_HI: st_d.dbc[CW-1:DW] = wr_data;
                WI_ADR_LO: st_d.dac[DW-1:0]  = wr_data;
                WI_ADR_HI: st_d.dac[CW-1:DW] = wr_data;
                WI_TRIG: begin
                    if (st_q.ifctrl[IFC_XFER_EN]) begin
                        st_d.ifstat[IFS_IDLE] = 1'b0;
                        st_d.start            = 1'b1;
                    end
                end
                WI_ACK: begin
                    st_d.ifstat[IFS_END_N] = 1'b1;
                    st_d.ack               = 1'b1;
                end
                WI_WA_LO:  st_d.wa[DW-1:0]  = wr_data;
                WI_WA_HI:  st_d.wa[CW-1:DW] = wr_data;
                WI_CTL0:   st_d.ctrl0 = wr_data;
                WI_CTL1:   st_d.ctrl1 = wr_data;
                WI_PTR_LO: st_d.pt[DW-1:0]  = wr_data;
                WI_PTR_HI: st_d.pt[CW-1:DW] = wr_data;
                WI_CTL2:   st_d.ctrl2 = wr_data;
                WI_SRST:   st_d = reset_state();
            endcase
        end

        st_d.idx = idx_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx    = st_q.idx;
    assign xfer_start = st_q.start;
    assign xfer_stop  = st_q.stop;
    assign xfer_ack   = st_q.ack;
    assign byte_cnt   = st_q.dbc;
    assign data_addr  = st_q.dac;
    assign ctrl_word  = {st_q.ctrl2, st_q.ctrl1, st_q.ctrl0};
    assign subhdr_out = st_q.sbout;

endmodule

// File: rtl/cdc_regwin_chk.sv
module cdc_regwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic        idx_set,
    input logic [3:0]  idx_val,
    input logic [3:0]  cur_idx,
    input logic        xfer_start,
    input logic        xfer_stop,
    input logic        xfer_ack,
    input logic [15:0] byte_cnt
);
    // R4
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !idx_set && cur_idx != 4'd15) |=> cur_idx == 4'($past(cur_idx) + 4'd1));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !idx_set && cur_idx == 4'd15) |=> cur_idx == 4'd15);

    // R3
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_set |=> cur_idx == $past(idx_val));

    // R7
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_start) |-> $past(wr_stb && cur_idx == 4'd6));

    // R8
    ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_ack) |-> $past(wr_stb && cur_idx == 4'd7));

    // R6
    stop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stop |-> byte_cnt == 16'd0);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, xfer_stop, xfer_ack}));
endmodule

bind cdc_regwin cdc_regwin_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .idx_set    (idx_set),
    .idx_val    (idx_val),
    .cur_idx    (cur_idx),
    .xfer_start (xfer_start),
    .xfer_stop  (xfer_stop),
    .xfer_ack   (xfer_ack),
    .byte_cnt   (byte_cnt)
);

// File: tb/cdc_regwin_test.sv
module cdc_regwin_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, idx_set = 1'b0;
    logic [3:0]  idx_val = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  cur_idx;
    logic [7:0]  bcd_min = 8'h12, bcd_sec = 8'h34, bcd_frm = 8'h56;
    logic        xfer_end = 1'b0, dec_done = 1'b0;
    logic        xfer_start, xfer_stop, xfer_ack;
    logic [15:0] byte_cnt, data_addr;
    logic [23:0] ctrl_word;
    logic [7:0]  subhdr_out;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    cdc_regwin uut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .idx_set(idx_set), .idx_val(idx_val), .wr_data(wr_data),
        .rd_data(rd_data), .cur_idx(cur_idx),
        .bcd_min(bcd_min), .bcd_sec(bcd_sec), .bcd_frm(bcd_frm),
        .xfer_end(xfer_end), .dec_done(dec_done),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop), .xfer_ack(xfer_ack),
        .byte_cnt(byte_cnt), .data_addr(data_addr),
        .ctrl_word(ctrl_word), .subhdr_out(subhdr_out)
    );

    typedef struct packed {
        logic [1:0] op;    // 0 load index, 1 read, 2 write
        logic [3:0] ix;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] nidx;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd0,  8'h00, 1'b0, 8'h00, 4'd0},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd1},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'hFF, 4'd2},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd3},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd4},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h12, 4'd5},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h34, 4'd6},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h56, 4'd7},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h01, 4'd8},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd9},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd10},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h60, 4'd11},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h12, 4'd12},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h80, 4'd13},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd14},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd15},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd15},
        '{2'd0, 4'd2,  8'h00, 1'b0, 8'h00, 4'd2},
        '{2'd2, 4'd0,  8'h34, 1'b0, 8'h00, 4'd3},
        '{2'd2, 4'd0,  8'h12, 1'b0, 8'h00, 4'd4},
        '{2'd0, 4'd2,  8'h00, 1'b0, 8'h00, 4'd2},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h34, 4'd3},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h12, 4'd4},
        '{2'd0, 4'd8,  8'h00, 1'b0, 8'h00, 4'd8},
        '{2'd2, 4'd0,  8'hCD, 1'b0, 8'h00, 4'd9},
        '{2'd2, 4'd0,  8'hAB, 1'b0, 8'h00, 4'd10},
        '{2'd0, 4'd10, 8'h00, 1'b0, 8'h00, 4'd10},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'hCD, 4'd11},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'hAB, 4'd12},
        '{2'd0, 4'd12, 8'h00, 1'b0, 8'h00, 4'd12},
        '{2'd2, 4'd0,  8'h11, 1'b0, 8'h00, 4'd13},
        '{2'd2, 4'd0,  8'h22, 1'b0, 8'h00, 4'd14},
        '{2'd2, 4'd0,  8'h77, 1'b0, 8'h00, 4'd14},
        '{2'd0, 4'd8,  8'h00, 1'b0, 8'h00, 4'd8},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h11, 4'd9},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h22, 4'd10},
        '{2'd0, 4'd0,  8'h00, 1'b0, 8'h00, 4'd0},
        '{2'd2, 4'd0,  8'h5A, 1'b0, 8'h00, 4'd1},
        '{2'd0, 4'd7,  8'h00, 1'b0, 8'h00, 4'd7},
        '{2'd2, 4'd0,  8'h00, 1'b0, 8'h00, 4'd7},
        '{2'd0, 4'd14, 8'h00, 1'b0, 8'h00, 4'd14},
        '{2'd1, 4'd0,  8'h00, 1'b1, 8'h00, 4'd15}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access spanning one rising edge; rdv is read data before the edge
    task automatic access(input logic rd, input logic wr, input logic ld,
                          input logic [3:0] lv, input logic [7:0] wd,
                          output logic [7:0] rdv);
        @(negedge clk);
        rd_stb = rd; wr_stb = wr; idx_set = ld; idx_val = lv; wr_data = wd;
        #1 rdv = rd_data;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; idx_set = 1'b0;
    endtask

    task automatic seti(input logic [3:0] v);
        logic [7:0] d;
        access(1'b0, 1'b0, 1'b1, v, 8'h00, d);
    endtask

    task automatic wr(input logic [7:0] v);
        logic [7:0] d;
        access(1'b0, 1'b1, 1'b0, 4'd0, v, d);
    endtask

    task automatic rd(output logic [7:0] v);
        access(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, v);
    endtask

    task automatic pulse_in(input logic which_end);
        @(negedge clk);
        if (which_end) xfer_end = 1'b1; else dec_done = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0; dec_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        check("R1 index", 32'(cur_idx), 32'd0);
        check("R1 cmd-in", 32'(rd_data), 32'h00);
        check("R1 pulses", 32'({xfer_start, xfer_stop, xfer_ack}), 32'd0);
        check("R1 count/addr", {byte_cnt, data_addr}, 32'd0);
        check("R1 ctrl", 32'(ctrl_word), 32'd0);

        // R1 R2 R4 vector walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].op == 2'd1, VEC[i].op == 2'd2, VEC[i].op == 2'd0,
                   VEC[i].ix, VEC[i].wd, v);
            if (VEC[i].chk) check($sformatf("R1/R4 vector %0d data", i), 32'(v), 32'(VEC[i].exp));
            check($sformatf("R2 vector %0d index", i), 32'(cur_idx), 32'(VEC[i].nidx));
        end
        check("R4 sub-header out", 32'(subhdr_out), 32'h5A);
        check("R4 ctrl2", 32'(ctrl_word[23:16]), 32'h77);

        // R4 data address
        seti(4'd4); wr(8'h78); wr(8'h56);
        check("R4 data address", 32'(data_addr), 32'h5678);
        // R7 trigger ignored with transfer disabled; R2 index held at 6
        wr(8'h00);
        check("R7 no start", 32'(xfer_start), 32'd0);
        check("R2 hold at 6", 32'(cur_idx), 32'd6);

        // R7 start
        seti(4'd1); wr(8'h42);
        check("R6 no stop when enabled", 32'(xfer_stop), 32'd0);
        seti(4'd6); wr(8'h00);
        check("R7 start pulse", 32'(xfer_start), 32'd1);
        seti(4'd1); rd(v);
        check("R7 busy status", 32'(v), 32'hF7);
        // R9 end of transfer
        pulse_in(1'b1);
        seti(4'd1); rd(v);
        check("R9 end flag", 32'(v), 32'hBF);
        // R8 acknowledge
        seti(4'd7); wr(8'h00);
        check("R8 ack pulse", 32'(xfer_ack), 32'd1);
        seti(4'd1); rd(v);
        check("R8 flag cleared", 32'(v), 32'hFF);

        // R6 stop
        seti(4'd1); wr(8'h02);
        seti(4'd6); wr(8'h00);
        seti(4'd1); rd(v);
        check("R7 busy again", 32'(v), 32'hF7);
        check("R6 count before stop", 32'(byte_cnt), 32'h1234);
        seti(4'd1); wr(8'h00);
        check("R6 stop pulse", 32'(xfer_stop), 32'd1);
        rd(v); check("R6 count low", 32'(v), 32'h00);
        rd(v); check("R6 count high", 32'(v), 32'h00);
        seti(4'd1); rd(v);
        check("R6 idle status", 32'(v), 32'hFF);

        // R5 header modes
        seti(4'd11); wr(8'h01);
        seti(4'd4);
        for (int k = 0; k < 4; k++) begin
            rd(v); check($sformatf("R5 sub-header byte %0d", k), 32'(v), 32'h00);
        end
        seti(4'd11); wr(8'h00);
        seti(4'd7); rd(v);
        check("R5 mode byte", 32'(v), 32'h01);

        // R3 load during a read
        seti(4'd3);
        access(1'b1, 1'b0, 1'b1, 4'd9, 8'h00, v);
        check("R3 old index data", 32'(v), 32'h00);
        check("R3 loaded index", 32'(cur_idx), 32'd9);

        // R10 decode flag
        pulse_in(1'b0);
        seti(4'd1); rd(v);
        check("R10 decode flag low", 32'(v), 32'hDF);
        seti(4'd15); rd(v);
        check("R2 hold at 15", 32'(cur_idx), 32'd15);
        seti(4'd1); rd(v);
        check("R10 decode flag cleared", 32'(v), 32'hFF);

        // R12 soft reset
        seti(4'd15); wr(8'h00);
        check("R12 index stays", 32'(cur_idx), 32'd15);
        check("R12 data address", 32'(data_addr), 32'd0);
        seti(4'd10); rd(v);
        check("R12 write addr low", 32'(v), 32'h60);
        rd(v);
        check("R12 write addr high", 32'(v), 32'h12);
        seti(4'd8); rd(v);
        check("R12 pointer", 32'(v), 32'h00);

        // R11 re-arm gated by read record (record now only partial)
        seti(4'd10); wr(8'h80);
        seti(4'd1); wr(8'h20);
        seti(4'd15); rd(v); rd(v);
        check("R11 partial record", 32'(v), 32'h00);
        seti(4'd1);
        for (int k = 1; k < 15; k++) rd(v);
        rd(v);
        check("R11 old value on arming read", 32'(v), 32'h00);
        rd(v);
        check("R11 armed", 32'(v), 32'h80);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule